// File: doc/BRIEF.md
# Column-Order Bank Router for a Quasi-Cyclic Decoder

This block forms the column-order read path of a partly parallel quasi-cyclic low-density parity-check decoder. Check-to-variable messages sit row-wise in a message memory: row r of a Z-row circulant lives at location r. With parallel factor 1 there is one bank of Z locations. With parallel factor 2 the rows are split into two half-banks of Z/2 locations each. Variable-node processing has to visit the messages in column order, so the block walks an index table. It presents each entry as a read address to the message memory and hands the returned words to the variable-node lanes.

The index table is built at elaboration from the circulant size and shift parameters. For parallel factor 2, each entry carries a location plus a bank tag. The two bank words read from the same location belong to a column in the first half and a column in the second half. The tag decides which of them goes to lane A (first-half columns) and which to lane B (second-half columns). Each column passes through three overlapped stages: the table lookup, the memory read, and the write-back cycle. The write-back cycle presents the lane data together with the location that was read, so the updated messages can be returned to the same place. A start pulse launches one sweep, and a done pulse closes it.

Top module: `colRouter`

## Requirements
- R1: While reset is asserted and right after it, busy, done, memRdEn, laneValid and wbValid are all 0.
- R2: A start sampled high while busy is 0 begins a sweep. memRdEn is high in the second cycle after that edge and stays high for exactly STEPS = Z/PF consecutive cycles, with one table step per cycle.
- R3: With PF = 1, the read location for step j is the row (j − SHIFT) mod Z. With the defaults Z = 12 and SHIFT = 3, the order is 9, 10, 11, 0, 1, … 8 (zero-based).
- R4: With PF = 2, step j serves column j on lane A and column j + Z/2 on lane B. Let r = (j − SHIFT) mod Z. The read location is r mod (Z/2), and the tag is 1 exactly when r ≥ Z/2.
- R5: Bank A holds rows 0 … Z/2−1 and bank B holds rows Z/2 … Z−1, each at location r − base. With tag 0, lane A receives the bank A word and lane B the bank B word. With tag 1 the two are swapped. As a result, lane A always carries row (j − SHIFT) mod Z and lane B carries row (j + Z/2 − SHIFT) mod Z.
- R6: The message memory answers one cycle after memRdEn. In that cycle laneValid and wbValid are high, and wbAddr and wbTag equal the location and tag that were read the cycle before.
- R7: busy is high from the cycle after the accepting edge through the last write-back cycle. done is a single-cycle pulse in the cycle after the last write-back, and busy is 0 in that cycle.
- R8: A start pulse while busy is high is ignored: the running sweep continues unchanged and produces exactly STEPS write-backs.
- R9: A start sampled in the done cycle is accepted, so a new sweep follows back to back, with busy high in the next cycle.
- R10: With PF = 1, wbTag is always 0, and lane B passes the bank B read word through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a sweep when idle |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse after the last write-back |
| memRdEn | output | 1 | Read strobe to the message memory |
| memAddr | output | ADDR_W | Read location, shared by both banks |
| bankAData | input | MSG_W | Bank A read word, valid the cycle after memRdEn |
| bankBData | input | MSG_W | Bank B read word, valid the cycle after memRdEn |
| laneValid | output | 1 | Lane data valid |
| laneAData | output | MSG_W | Message for the first-half column lane |
| laneBData | output | MSG_W | Message for the second-half column lane |
| wbValid | output | 1 | Write-back slot valid |
| wbAddr | output | ADDR_W | Write-back location (the one read one cycle earlier) |
| wbTag | output | 1 | Bank tag of the write-back slot |

## Verification
Two events can share a cycle: the done pulse that ends one sweep and the acceptance of the start that opens the next. The bench raises start exactly in the done cycle and checks that busy returns at once and that the new sweep's read and write-back stream follows with no gap. It also pulses start in the middle of a sweep, where the same request must be dropped. A cycle-by-cycle model predicts every output, including lane contents derived from the row each column needs, for both parallel factors.

// File: rtl/colRouterPkg.sv
package colRouterPkg;

  // control -> datapath strobes
  typedef struct packed {
    logic issue;
    logic last;
  } strobeT;

  // datapath -> control status
  typedef struct packed {
    logic occupied;
    logic lastWb;
  } pipeStatT;

  // row holding the nonzero entry of column col in a circulant shifted by shift
  function automatic int rowOfCol(input int col, input int z, input int shift);
    return ((col - (shift % z)) + z) % z;
  endfunction

endpackage

// File: rtl/colIdxRom.sv
module colIdxRom #(
  parameter int Z      = 12,
  parameter int SHIFT  = 3,
  parameter int PF     = 2,
  parameter int STEPS  = Z / PF,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] loc,
  output logic              tag
);
  localparam int HALF  = Z / PF;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] locTab [DEPTH];
  logic              tagTab [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : gEntry
    if (j < STEPS) begin : gUsed
      localparam int ROW    = colRouterPkg::rowOfCol(j, Z, SHIFT);
      localparam bit IS_HI  = (PF == 2) && (ROW >= HALF);
      localparam int LOCVAL = IS_HI ? ROW - HALF : ROW;
      assign locTab[j] = ADDR_W'(LOCVAL);
      assign tagTab[j] = IS_HI;
    end else begin : gPad
      assign locTab[j] = '0;
      assign tagTab[j] = 1'b0;
    end
  end

  assign loc = locTab[step];
  assign tag = tagTab[step];

endmodule

// File: rtl/colRouterCtrl.sv
module colRouterCtrl #(
  parameter int STEPS  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  colRouterPkg::pipeStatT   dpStat,
  output colRouterPkg::strobeT     stb,
  output logic [ADDR_W-1:0]        step,
  output logic                     busy,
  output logic                     done
);
  logic              issuing;
  logic [ADDR_W-1:0] stepQ;
  logic              atLast;

  assign atLast = (stepQ == ADDR_W'(STEPS - 1));
  assign busy   = issuing | dpStat.occupied;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issuing <= 1'b0;
      stepQ   <= '0;
      done    <= 1'b0;
    end else begin
      done <= dpStat.lastWb;
      if (start && !busy) begin
        issuing <= 1'b1;
        stepQ   <= '0;
      end else if (issuing) begin
        if (atLast) begin
          issuing <= 1'b0;
          stepQ   <= '0;
        end else begin
          stepQ <= stepQ + 1'b1;
        end
      end
    end
  end

  assign stb.issue = issuing;
  assign stb.last  = issuing & atLast;
  assign step      = stepQ;

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (issuing && !atLast) |=> (issuing && stepQ == $past(stepQ) + 1'b1)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

endmodule

// File: rtl/colRouterDp.sv
module colRouterDp #(
  parameter int Z      = 12,
  parameter int SHIFT  = 3,
  parameter int PF     = 2,
  parameter int MSG_W  = 6,
  parameter int STEPS  = Z / PF,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  colRouterPkg::strobeT    stb,
  input  logic [ADDR_W-1:0]       step,
  output logic                    memRdEn,
  output logic [ADDR_W-1:0]       memAddr,
  input  logic [MSG_W-1:0]        bankAData,
  input  logic [MSG_W-1:0]        bankBData,
  output logic                    laneValid,
  output logic [MSG_W-1:0]        laneAData,
  output logic [MSG_W-1:0]        laneBData,
  output logic                    wbValid,
  output logic [ADDR_W-1:0]       wbAddr,
  output logic                    wbTag,
  output colRouterPkg::pipeStatT  dpStat
);
  logic [ADDR_W-1:0] romLoc;
  logic              romTag;

  colIdxRom #(
    .Z(Z), .SHIFT(SHIFT), .PF(PF), .STEPS(STEPS), .ADDR_W(ADDR_W)
  ) uRom (
    .step(step),
    .loc (romLoc),
    .tag (romTag)
  );

  // stage 1: table entry captured, drives the memory read
  logic              s1Valid, s1Last, s1Tag;
  logic [ADDR_W-1:0] s1Loc;
  // stage 2: memory data arrives, write-back slot
  logic              s2Valid, s2Last, s2Tag;
  logic [ADDR_W-1:0] s2Loc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Last  <= 1'b0;
      s1Tag   <= 1'b0;
      s1Loc   <= '0;
      s2Valid <= 1'b0;
      s2Last  <= 1'b0;
      s2Tag   <= 1'b0;
      s2Loc   <= '0;
    end else begin
      s1Valid <= stb.issue;
      s1Last  <= stb.last;
      if (stb.issue) begin
        s1Tag <= romTag;
        s1Loc <= romLoc;
      end
      s2Valid <= s1Valid;
      s2Last  <= s1Valid & s1Last;
      if (s1Valid) begin
        s2Tag <= s1Tag;
        s2Loc <= s1Loc;
      end
    end
  end

  assign memRdEn = s1Valid;
  assign memAddr = s1Loc;

  assign laneValid = s2Valid;
  assign wbValid   = s2Valid;
  assign wbAddr    = s2Loc;
  assign wbTag     = s2Tag;

  assign dpStat.occupied = s1Valid | s2Valid;
  assign dpStat.lastWb   = s2Valid & s2Last;

  if (PF == 2) begin : gSwap
    always_comb begin
      if (s2Tag) begin
        laneAData = bankBData;
        laneBData = bankAData;
      end else begin
        laneAData = bankAData;
        laneBData = bankBData;
      end
    end
  end else begin : gSingle
    assign laneAData = bankAData;
    assign laneBData = bankBData;

    AST_TAG_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      wbValid |-> !wbTag); // R10
  end

  AST_READ_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> $past(stb.issue)); // R2

  AST_WB_MATCHES_READ: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> ($past(memRdEn) && wbAddr == $past(memAddr))); // R6

  AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> ({1'b0, memAddr} < (ADDR_W + 1)'(STEPS))); // R4

endmodule

// File: rtl/colRouter.sv
module colRouter #(
  parameter int Z     = 12,
  parameter int SHIFT = 3,
  parameter int PF    = 2,
  parameter int MSG_W = 6,
  localparam int STEPS  = Z / PF,
  localparam int ADDR_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [MSG_W-1:0]  bankAData,
  input  logic [MSG_W-1:0]  bankBData,
  output logic              laneValid,
  output logic [MSG_W-1:0]  laneAData,
  output logic [MSG_W-1:0]  laneBData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              wbTag
);
  colRouterPkg::strobeT   stb;
  colRouterPkg::pipeStatT dpStat;
  logic [ADDR_W-1:0]      step;

  colRouterCtrl #(
    .STEPS(STEPS), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .dpStat(dpStat),
    .stb   (stb),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  colRouterDp #(
    .Z(Z), .SHIFT(SHIFT), .PF(PF), .MSG_W(MSG_W), .STEPS(STEPS), .ADDR_W(ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .step     (step),
    .memRdEn  (memRdEn),
    .memAddr  (memAddr),
    .bankAData(bankAData),
    .bankBData(bankBData),
    .laneValid(laneValid),
    .laneAData(laneAData),
    .laneBData(laneBData),
    .wbValid  (wbValid),
    .wbAddr   (wbAddr),
    .wbTag    (wbTag),
    .dpStat   (dpStat)
  );

  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(wbValid) && !wbValid)); // R7

endmodule

// File: tb/colRouterRef.sv
module colRouterRef #(
  parameter int Z      = 12,
  parameter int SHIFT  = 3,
  parameter int PF     = 2,
  parameter int MSG_W  = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  int                seed,
  input  logic              busy,
  input  logic              done,
  input  logic              memRdEn,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              laneValid,
  input  logic [MSG_W-1:0]  laneAData,
  input  logic [MSG_W-1:0]  laneBData,
  input  logic              wbValid,
  input  logic [ADDR_W-1:0] wbAddr,
  input  logic              wbTag,
  output logic [MSG_W-1:0]  bankAData,
  output logic [MSG_W-1:0]  bankBData
);
  localparam int S     = Z / PF;
  localparam int HALF  = Z / PF;
  localparam int BFILL = 42 % (1 << MSG_W);

  int nChecks = 0;
  int nErrors = 0;

  int edgeN = 0;
  int sweepStart = -1;
  bit expBusy = 0, expDone = 0, expRd = 0, expWb = 0, expTag = 0;
  int expAddr = 0, expWbAddr = 0, expLaneA = 0, expLaneB = 0;

  function automatic int rowOf(input int col);
    return ((col - (SHIFT % Z)) + Z) % Z;
  endfunction

  function automatic int val(input int row);
    return (row * 7 + seed * 13 + 1) % (1 << MSG_W);
  endfunction

  function automatic int locOf(input int j);
    return (PF == 2) ? rowOf(j) % HALF : rowOf(j);
  endfunction

  function automatic bit tagOf(input int j);
    return (PF == 2) && (rowOf(j) >= HALF);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // message memory model: synchronous read, rows placed per bank
  always @(posedge clk) begin
    if (memRdEn) begin
      bankAData <= MSG_W'(val(int'(memAddr)));
      if (PF == 2) bankBData <= MSG_W'(val(HALF + int'(memAddr)));
      else         bankBData <= MSG_W'(BFILL);
    end
  end

  // cycle model: predicts outputs for the cycle that follows each edge
  always @(posedge clk) begin
    int k;
    if (!rstN) begin
      edgeN = 0;
      sweepStart = -1;
      expBusy = 0;
    end else begin
      edgeN++;
      if (start && !expBusy) sweepStart = edgeN;
    end
    k = (sweepStart >= 0) ? edgeN - sweepStart : -100;
    expBusy = (k >= 0) && (k <= S + 1);
    expRd   = (k >= 1) && (k <= S);
    expWb   = (k >= 2) && (k <= S + 1);
    expDone = (k == S + 2);
    if (expRd) expAddr = locOf(k - 1);
    if (expWb) begin
      expWbAddr = locOf(k - 2);
      expTag    = tagOf(k - 2);
      expLaneA  = val(rowOf(k - 2));
      expLaneB  = (PF == 2) ? val(rowOf(k - 2 + HALF)) : BFILL;
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      chk("R1", "busy in reset", int'(busy), 0);
      chk("R1", "done in reset", int'(done), 0);
      chk("R1", "memRdEn in reset", int'(memRdEn), 0);
      chk("R1", "laneValid in reset", int'(laneValid), 0);
      chk("R1", "wbValid in reset", int'(wbValid), 0);
    end else begin
      chk("R7", "busy", int'(busy), int'(expBusy));
      chk("R7", "done", int'(done), int'(expDone));
      chk("R2", "memRdEn", int'(memRdEn), int'(expRd));
      chk("R6", "wbValid", int'(wbValid), int'(expWb));
      chk("R6", "laneValid", int'(laneValid), int'(expWb));
      if (expRd && memRdEn)
        chk((PF == 2) ? "R4" : "R3", "memAddr", int'(memAddr), expAddr);
      if (expWb && wbValid) begin
        chk("R6", "wbAddr", int'(wbAddr), expWbAddr);
        chk((PF == 2) ? "R4" : "R10", "wbTag", int'(wbTag), int'(expTag));
        chk("R5", "laneAData", int'(laneAData), expLaneA);
        chk((PF == 2) ? "R5" : "R10", "laneBData", int'(laneBData), expLaneB);
      end
    end
  end

endmodule

// File: tb/sim_colRouter.sv
module sim_colRouter;
  localparam int Z = 12;
  localparam int SHIFT = 3;
  localparam int MSG_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start0 = 1'b0, start1 = 1'b0;
  int   seed = 1;

  always #10 clk = ~clk; // 50 MHz

  // parallel factor 2 instance
  logic busy0, done0, rd0, lv0, wb0, tag0;
  logic [2:0] addr0, wba0;
  logic [MSG_W-1:0] bA0, bB0, lA0, lB0;

  // parallel factor 1 instance
  logic busy1, done1, rd1, lv1, wb1, tag1;
  logic [3:0] addr1, wba1;
  logic [MSG_W-1:0] bA1, bB1, lA1, lB1;

  colRouter #(.Z(Z), .SHIFT(SHIFT), .PF(2), .MSG_W(MSG_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start0), .busy(busy0), .done(done0),
    .memRdEn(rd0), .memAddr(addr0), .bankAData(bA0), .bankBData(bB0),
    .laneValid(lv0), .laneAData(lA0), .laneBData(lB0),
    .wbValid(wb0), .wbAddr(wba0), .wbTag(tag0));

  colRouter #(.Z(Z), .SHIFT(SHIFT), .PF(1), .MSG_W(MSG_W)) u1 (
    .clk(clk), .rstN(rstN), .start(start1), .busy(busy1), .done(done1),
    .memRdEn(rd1), .memAddr(addr1), .bankAData(bA1), .bankBData(bB1),
    .laneValid(lv1), .laneAData(lA1), .laneBData(lB1),
    .wbValid(wb1), .wbAddr(wba1), .wbTag(tag1));

  colRouterRef #(.Z(Z), .SHIFT(SHIFT), .PF(2), .MSG_W(MSG_W), .ADDR_W(3)) m0 (
    .clk(clk), .rstN(rstN), .start(start0), .seed(seed), .busy(busy0), .done(done0),
    .memRdEn(rd0), .memAddr(addr0), .laneValid(lv0), .laneAData(lA0), .laneBData(lB0),
    .wbValid(wb0), .wbAddr(wba0), .wbTag(tag0), .bankAData(bA0), .bankBData(bB0));

  colRouterRef #(.Z(Z), .SHIFT(SHIFT), .PF(1), .MSG_W(MSG_W), .ADDR_W(4)) m1 (
    .clk(clk), .rstN(rstN), .start(start1), .seed(seed), .busy(busy1), .done(done1),
    .memRdEn(rd1), .memAddr(addr1), .laneValid(lv1), .laneAData(lA1), .laneBData(lB1),
    .wbValid(wb1), .wbAddr(wba1), .wbTag(tag1), .bankAData(bA1), .bankBData(bB1));

  int benchChecks = 0;
  int benchErrors = 0;
  int wbCnt0 = 0, wbCnt1 = 0;
  int cyc = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    benchChecks++;
    if (act != exp) begin
      benchErrors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors",
             benchChecks + m0.nChecks + m1.nChecks,
             benchErrors + m0.nErrors + m1.nErrors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (wb0) wbCnt0++;
    if (wb1) wbCnt1++;
    cyc++;
    if (cyc == 5000) begin
      benchChecks++;
      benchErrors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 5000);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // plain sweeps on both parallel factors (R2..R6, R10)
    start0 = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    repeat (20) @(negedge clk);

    // start pulses in mid-sweep are ignored (R8)
    seed = 2;
    wbCnt0 = 0; wbCnt1 = 0;
    start0 = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    repeat (2) @(negedge clk);
    start0 = 1'b1; start1 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; start1 = 1'b0;
    repeat (3) @(negedge clk);
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8", "write-backs in one sweep, PF2", wbCnt0, Z / 2);
    chk("R8", "write-backs in one sweep, PF1", wbCnt1, Z);

    // start in the done cycle starts the next sweep back to back (R9)
    seed = 3;
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    do @(negedge clk); while (!done0);
    chk("R9", "busy during done, PF2", int'(busy0), 0);
    start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0;
    chk("R9", "busy after back-to-back start, PF2", int'(busy0), 1);
    repeat (12) @(negedge clk);

    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    do @(negedge clk); while (!done1);
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    chk("R9", "busy after back-to-back start, PF1", int'(busy1), 1);
    repeat (20) @(negedge clk);

    finishRun();
  end

endmodule